// File: doc/BRIEF.md
# Mode-Selectable Split Approximate Adder

This block adds two N-bit operands and returns an N+1-bit sum. The addition is split at bit P. The upper N-P bits always form an exact adder, built from 4-bit carry look-ahead groups. The lower P bits form an inexact lane whose logic is picked by a static mode code.

Eight approximation schemes are offered. They differ in how the low sum bits are formed and in what carry, if any, enters the upper adder. A ninth setting adds exactly across the full width and acts as the reference. It is meant for error-tolerant datapaths such as transform stages in image coding, where the mode trades accuracy against the depth of the carry path. The defaults are N=21 and P=11.

Optional registers sit on the operand side and on the sum side. With both enabled, which is the default, a result leaves the block two clock edges after its operands enter. A synchronous active-high reset clears both register stages to zero.

Top module: `approx_split_adder`

## Requirements
In the text below, "lo" means bits P-1..0, and a and b are the operands. The expression g = a[P-1] AND b[P-1], and t = a[P-2] AND b[P-2]. "Ones region" means sum bits P-3..0. c is the carry passed from the low lane into the upper adder.

- R1: Mode code 0 gives the exact sum a+b over all N+1 bits.
- R2: Mode code 1 sets each low sum bit to the OR of the operand bits, and c = g.
- R3: Mode code 2 sets each low sum bit to the OR of the operand bits, and c = 0.
- R4: Mode code 3 copies a's low bits to the low sum and sets c = b[P-1]. b's bits P-2..0 have no effect on the sum.
- R5: Mode code 4 uses OR for the low sum bits but forces sum bit P-1 to 0 when g=1, and c = g.
- R6: Mode code 5 behaves as code 4, except that the ones region is forced to 1.
- R7: Mode code 6 behaves as code 1, except that the ones region is forced to 1.
- R8: Mode code 7 forces the ones region to 1. Sum bit P-2 is a[P-2] OR b[P-2]. Sum bit P-1 is t when g=1, and a[P-1] OR b[P-1] when g=0. c = g.
- R9: Mode code 8 behaves as code 7, except that sum bit P-1 is (a[P-1] OR b[P-1]) OR t when g=0.
- R10: Sum bits N..P always equal a[N-1:P] + b[N-1:P] + c, and bit N is that addition's carry-out.
- R11: With both register stages enabled, the sum for operands presented before a rising edge appears after the following rising edge. While reset is high, the sum output reads 0.
- R12: Mode codes 9 to 15 are not defined and give the exact sum a+b, as code 0 does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| mode_i | input | 4 | Approximation scheme code |
| sum_o | output | N+1 | Sum; bit N is the upper adder's carry-out |

## Verification
With both register stages in place, operands driven after a falling edge are captured at the next rising edge. Their sum is registered at the rising edge after that, so it can be read at the second falling edge after the drive.

The bench drives a new vector at every falling edge and keeps a two-entry queue of expected sums. At each falling edge it compares the output against the entry from two drives earlier. It does this before driving again, so every comparison falls halfway between edges.

A small configuration (N=6, P=4) lets the sweep cover every operand pair under all sixteen mode codes. The reset output is checked while reset is still held.

// File: rtl/apx_pkg.sv
package apx_pkg;

    typedef enum logic [3:0] {
        MD_EXACT    = 4'd0,
        MD_ORC      = 4'd1,
        MD_ORN      = 4'd2,
        MD_FWD      = 4'd3,
        MD_GZ       = 4'd4,
        MD_GZ_ONES  = 4'd5,
        MD_ORC_ONES = 4'd6,
        MD_MUX_A    = 4'd7,
        MD_MUX_B    = 4'd8
    } mode_e;

    // Generate / propagate pair of one bit position
    typedef struct packed {
        logic gen;
        logic prp;
    } lane_t;

    localparam int unsigned GRP_W = 4;

    // Undefined codes map to the exact mode
    function automatic mode_e mode_decode(input logic [3:0] code);
        if (code <= 4'd8) return mode_e'(code);
        return MD_EXACT;
    endfunction

    function automatic logic uses_ones(input mode_e md);
        return (md == MD_GZ_ONES) || (md == MD_ORC_ONES) ||
               (md == MD_MUX_A)   || (md == MD_MUX_B);
    endfunction

endpackage

// File: rtl/apx_pipe_reg.sv
module apx_pipe_reg #(
    parameter int unsigned W  = 8,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/apx_cla.sv
module apx_cla
    import apx_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned NG = (W + GRP_W - 1) / GRP_W;
    localparam int unsigned WP = NG * GRP_W;

    logic [WP-1:0] ax, bx;
    lane_t [WP-1:0] ln;
    logic [WP:0]   cv;
    logic [NG:0]   gc;

    assign ax = WP'(a);
    assign bx = WP'(b);
    assign gc[0] = cin;

    generate
        for (genvar i = 0; i < WP; i++) begin : g_bit
            assign ln[i].gen = ax[i] & bx[i];
            assign ln[i].prp = ax[i] ^ bx[i];
        end

        for (genvar k = 0; k < NG; k++) begin : g_grp
            localparam int unsigned B = k * GRP_W;
            logic p0, p1, p2, p3, g0, g1, g2, g3, c0;
            logic grp_g, grp_p;

            assign {p3, p2, p1, p0} = {ln[B+3].prp, ln[B+2].prp, ln[B+1].prp, ln[B].prp};
            assign {g3, g2, g1, g0} = {ln[B+3].gen, ln[B+2].gen, ln[B+1].gen, ln[B].gen};
            assign c0 = gc[k];

            // Look-ahead carries inside the group
            assign cv[B]   = c0;
            assign cv[B+1] = g0 | (p0 & c0);
            assign cv[B+2] = g1 | (p1 & g0) | (p1 & p0 & c0);
            assign cv[B+3] = g2 | (p2 & g1) | (p2 & p1 & g0) | (p2 & p1 & p0 & c0);

            assign grp_g = g3 | (p3 & g2) | (p3 & p2 & g1) | (p3 & p2 & p1 & g0);
            assign grp_p = p3 & p2 & p1 & p0;
            assign gc[k+1] = grp_g | (grp_p & c0);
        end
    endgenerate

    assign cv[WP] = gc[NG];

    generate
        for (genvar i = 0; i < W; i++) begin : g_sum
            assign sum[i] = ln[i].prp ^ cv[i];
        end
    endgenerate

    assign cout = cv[W];

    logic unused_pad;
    assign unused_pad = ^{cv[WP:W], ax, bx};
endmodule

// File: rtl/apx_low_lane.sv
module apx_low_lane
    import apx_pkg::*;
#(
    parameter int unsigned P = 11
) (
    input  logic [P-1:0] a,
    input  logic [P-1:0] b,
    input  mode_e        md,
    output logic [P-1:0] s,
    output logic         cout
);
    localparam logic [P-1:0] LOW_ONES = {P{1'b1}} >> 2;

    logic [P-1:0] or_v;
    logic         g_top;
    logic         t_sub;
    logic [P:0]   exact_v;

    assign or_v    = a | b;
    assign g_top   = a[P-1] & b[P-1];
    assign t_sub   = a[P-2] & b[P-2];
    assign exact_v = {1'b0, a} + {1'b0, b};

    always_comb begin
        s    = or_v;
        cout = g_top;
        unique case (md)
            MD_EXACT: begin
                s    = exact_v[P-1:0];
                cout = exact_v[P];
            end
            MD_ORC: ;
            MD_ORN: cout = 1'b0;
            MD_FWD: begin
                s    = a;
                cout = b[P-1];
            end
            MD_GZ: s[P-1] = or_v[P-1] & ~g_top;
            MD_GZ_ONES: begin
                s        = or_v | LOW_ONES;
                s[P-1]   = or_v[P-1] & ~g_top;
            end
            MD_ORC_ONES: s = or_v | LOW_ONES;
            MD_MUX_A: begin
                s      = or_v | LOW_ONES;
                s[P-1] = g_top ? t_sub : or_v[P-1];
            end
            MD_MUX_B: begin
                s      = or_v | LOW_ONES;
                s[P-1] = g_top ? t_sub : (or_v[P-1] | t_sub);
            end
            default: begin
                s    = exact_v[P-1:0];
                cout = exact_v[P];
            end
        endcase
    end
endmodule

// File: rtl/approx_split_adder.sv
module approx_split_adder
    import apx_pkg::*;
#(
    parameter int unsigned N       = 21,
    parameter int unsigned P       = 11,
    parameter bit          REG_IN  = 1'b1,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [3:0]   mode_i,
    output logic [N:0]   sum_o
);
    localparam int unsigned H  = N - P;
    localparam int unsigned IW = 2 * N + 4;
    localparam logic [P-1:0] LOW_ONES = {P{1'b1}} >> 2;

    logic [IW-1:0] in_d, in_q;
    logic [N-1:0]  a_q, b_q;
    logic [3:0]    mode_q;
    mode_e         md;

    logic [P-1:0]  lo_s;
    logic          lo_c;
    logic [H-1:0]  hi_s;
    logic          hi_c;
    logic [N:0]    sum_c;

    assign in_d = {mode_i, a_i, b_i};

    apx_pipe_reg #(.W(IW), .EN(REG_IN)) u_in_stage (
        .clk (clk),
        .rst (rst),
        .d   (in_d),
        .q   (in_q)
    );

    assign {mode_q, a_q, b_q} = in_q;
    assign md = mode_decode(mode_q);

    apx_low_lane #(.P(P)) u_low (
        .a    (a_q[P-1:0]),
        .b    (b_q[P-1:0]),
        .md   (md),
        .s    (lo_s),
        .cout (lo_c)
    );

    apx_cla #(.W(H)) u_high (
        .a    (a_q[N-1:P]),
        .b    (b_q[N-1:P]),
        .cin  (lo_c),
        .sum  (hi_s),
        .cout (hi_c)
    );

    assign sum_c = {hi_c, hi_s, lo_s};

    apx_pipe_reg #(.W(N+1), .EN(REG_OUT)) u_out_stage (
        .clk (clk),
        .rst (rst),
        .d   (sum_c),
        .q   (sum_o)
    );

    // Checks on the combinational stage
    AST_EXACT_FULL: assert property (@(posedge clk) disable iff (rst)
        (md == MD_EXACT) |-> sum_c == ({1'b0, a_q} + {1'b0, b_q})); // R1

    AST_HIGH_PART: assert property (@(posedge clk) disable iff (rst)
        sum_c[N:P] == ({1'b0, a_q[N-1:P]} + {1'b0, b_q[N-1:P]} + (H+1)'(lo_c))); // R10

    AST_NO_CARRY_MODE: assert property (@(posedge clk) disable iff (rst)
        (md == MD_ORN) |-> sum_c[N:P] == ({1'b0, a_q[N-1:P]} + {1'b0, b_q[N-1:P]})); // R3

    AST_FWD_PASS: assert property (@(posedge clk) disable iff (rst)
        (md == MD_FWD) |-> (sum_c[P-1:0] == a_q[P-1:0]) && (lo_c == b_q[P-1])); // R4

    AST_ONES_REGION: assert property (@(posedge clk) disable iff (rst)
        uses_ones(md) |-> ((sum_c[P-1:0] & LOW_ONES) == LOW_ONES)); // R6

    generate
        if (REG_OUT) begin : g_out_chk
            AST_OUT_DELAY: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> sum_o == $past(sum_c)); // R11
        end
    endgenerate
endmodule

// File: tb/approx_split_adder_test.sv
`timescale 1ns/1ps
module approx_split_adder_test;
    localparam int unsigned N = 6;
    localparam int unsigned P = 4;
    localparam int unsigned H = N - P;
    localparam logic [P-1:0] ONES_R = P'((1 << (P - 2)) - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic [3:0]   mode_i = '0;
    logic [N:0]   sum_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    approx_split_adder #(.N(N), .P(P), .REG_IN(1'b1), .REG_OUT(1'b1)) uut (
        .clk    (clk),
        .rst    (rst),
        .a_i    (a_i),
        .b_i    (b_i),
        .mode_i (mode_i),
        .sum_o  (sum_o)
    );

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [N:0] model(input logic [N-1:0] a, input logic [N-1:0] b,
                                         input logic [3:0] m);
        logic [P-1:0] al, bl, orl, lo;
        logic [H:0]   hs;
        logic         g, t, c;
        if (m == 4'd0 || m > 4'd8) return {1'b0, a} + {1'b0, b};
        al  = a[P-1:0];
        bl  = b[P-1:0];
        orl = al | bl;
        g   = al[P-1] & bl[P-1];
        t   = al[P-2] & bl[P-2];
        lo  = orl;
        c   = g;
        case (m)
            4'd2: c = 1'b0;
            4'd3: begin lo = al; c = bl[P-1]; end
            4'd4: if (g) lo[P-1] = 1'b0;
            4'd5: begin lo = orl | ONES_R; if (g) lo[P-1] = 1'b0; end
            4'd6: lo = orl | ONES_R;
            4'd7: begin lo = orl | ONES_R; lo[P-1] = g ? t : orl[P-1]; end
            4'd8: begin lo = orl | ONES_R; lo[P-1] = g ? t : (orl[P-1] | t); end
            default: ;
        endcase
        hs = {1'b0, a[N-1:P]} + {1'b0, b[N-1:P]} + (H+1)'(c);
        return {hs, lo};
    endfunction

    logic [N:0] ep0, ep1;
    logic       vp0 = 1'b0, vp1 = 1'b0;
    logic [3:0] mp0, mp1;

    // Drive after a falling edge; the result is due two falling edges later (R11, R10)
    task automatic step(input logic [N-1:0] a, input logic [N-1:0] b, input logic [3:0] m);
        @(negedge clk);
        if (vp1) begin
            checks++;
            if (sum_o !== ep1) begin
                errors++;
                $display("FAIL %s/R10/R11 mode=%0d actual=%0h expected=%0h",
                         req_of(mp1), mp1, sum_o, ep1);
            end
        end
        ep1 = ep0; vp1 = vp0; mp1 = mp0;
        ep0 = model(a, b, m); vp0 = 1'b1; mp0 = m;
        a_i = a; b_i = b; mode_i = m;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Operands during reset must not reach the output (R11)
        a_i = '1; b_i = '1; mode_i = 4'd0;
        repeat (4) @(negedge clk);
        checks++;
        if (sum_o !== '0) begin
            errors++;
            $display("FAIL R11 reset actual=%0h expected=0", sum_o);
        end
        rst = 1'b0;
        for (int m = 0; m < 16; m++)
            for (int a = 0; a < (1 << N); a++)
                for (int b = 0; b < (1 << N); b++)
                    step(N'(a), N'(b), 4'(m));
        step('0, '0, 4'd0);
        step('0, '0, 4'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule